// File: doc/BRIEF.md
# Framed Serial Two's Complement Negator

This block negates a bit-serial binary number while the number streams through it. One bit enters per clock, least significant bit first. The block returns the two's complement of the word on its output in the same cycle that each input bit is presented, so it adds no latency.

A one-cycle strobe marks the first bit of every word. The word length is therefore set by the spacing between strobes and may change from one word to the next. Inside the block there is a single flip-flop that records whether a 1 has already gone past in the current word.

Until that flag is set, each input bit is copied to the output unchanged; the bit that sets the flag is also copied. Once the flag is set, every later bit of the word is inverted. The strobe makes the current bit behave as if no 1 had been seen yet.

Top module: `serial_negator`

## Requirements
- R1: After synchronous reset, bits that arrive before any strobe are handled as the start of a word with no 1 seen, so the first such bit appears unchanged on the output.
- R2: Within a word, every bit up to and including the first 1 bit is copied unchanged to the output.
- R3: Within a word, every bit after the first 1 bit appears inverted on the output until the next strobe.
- R4: On a cycle with `word_start` high, the output equals `bit_in`, whatever the earlier words contained.
- R5: A word made only of 0 bits produces only 0 bits at the output.
- R6: A word one bit long is passed through unchanged, for both bit values.
- R7: For any word length n ≥ 1, the n output bits, read least significant first, form (2^n − x) mod 2^n, where x is the input word. Words follow one another with no idle cycles between them.
- R8: Each output bit depends on the present input bit and present state only, and is valid in the same cycle as its input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the "1 seen" flag |
| word_start | input | 1 | High on the cycle that carries the first bit of a new word |
| bit_in | input | 1 | Serial input bit, least significant bit first |
| bit_out | output | 1 | Serial two's complement output bit for the current cycle |

## Verification
The assertions assume that `word_start` and `bit_in` are stable around each rising edge. They also assume that every cycle after reset carries a meaningful bit, because the block has no idle state and treats every cycle as part of some word. The stimulus keeps within these assumptions: the bench changes the inputs only on falling edges, and it sends words back to back without gaps. The random words vary in length from 1 to 32 bits and take arbitrary values. Directed words cover the all-zero, single-bit and post-reset cases.

// File: rtl/serial_negator.sv
module serial_negator (
  input  logic clk,
  input  logic rst,
  input  logic word_start,
  input  logic bit_in,
  output logic bit_out
);
  logic seen_one;
  logic seen_next;
  logic flip;

  assign flip      = seen_one & ~word_start;
  assign bit_out   = bit_in ^ flip;
  assign seen_next = word_start ? bit_in : (seen_one | bit_in);

  always_ff @(posedge clk) begin
    if (rst) seen_one <= 1'b0;
    else     seen_one <= seen_next;
  end
endmodule

module serial_negator_chk (
  input logic clk,
  input logic rst,
  input logic word_start,
  input logic bit_in,
  input logic bit_out
);
  p_reset_pass_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bit_out == bit_in);

  p_start_pass_r4: assert property (@(posedge clk) disable iff (rst)
    word_start |-> bit_out == bit_in);

  p_invert_after_one_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !word_start && $past(bit_in)) |-> bit_out != bit_in);

  p_invert_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !word_start && $past(bit_out != bit_in)) |-> bit_out != bit_in);

  p_pass_after_zero_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !word_start && $past(word_start) && !$past(bit_in)) |-> bit_out == bit_in);

  p_zero_in_zero_out_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !word_start && $past(word_start) && !$past(bit_in) && !bit_in) |-> !bit_out);
endmodule

bind serial_negator serial_negator_chk u_chk (
  .clk(clk), .rst(rst), .word_start(word_start), .bit_in(bit_in), .bit_out(bit_out)
);

// File: tb/sim_serial_negator.sv
module sim_serial_negator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_start = 1'b0;
  logic bit_in = 1'b0;
  logic bit_out;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  item_t q[$];
  logic  drv_valid = 1'b0;
  int    total = 0;
  int    bad = 0;
  logic  finished = 1'b0;

  always #10 clk = ~clk;

  serial_negator u0 (
    .clk(clk), .rst(rst), .word_start(word_start), .bit_in(bit_in), .bit_out(bit_out)
  );

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: bit_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_word(input longint unsigned x, input int n, input logic strobe, input string req);
    longint unsigned mask;
    longint unsigned neg;
    mask = (n >= 64) ? '1 : ((64'd1 << n) - 1);
    neg  = ((~x) + 64'd1) & mask;
    for (int i = 0; i < n; i++) begin
      item_t it;
      @(negedge clk);
      word_start = (i == 0) ? strobe : 1'b0;
      bit_in     = x[i];
      it.exp = neg[i];
      it.req = req;
      q.push_back(it);
      drv_valid = 1'b1;
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      if (drv_valid && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(bit_out, it.exp, it.req);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #3000000;
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: first word after reset with no strobe, ones in it (value 0b1100 -> 0b0100)
    send_word(64'hC, 4, 1'b0, "R1");
    // R4: strobe resets state after inverting word
    send_word(64'h1, 1, 1'b1, "R4");
    send_word(64'h6, 3, 1'b1, "R4");
    // R5: all zero words
    send_word(64'h0, 5, 1'b1, "R5");
    send_word(64'h0, 1, 1'b1, "R5");
    // R6: single-bit words
    send_word(64'h1, 1, 1'b1, "R6");
    send_word(64'h1, 1, 1'b1, "R6");
    send_word(64'h0, 1, 1'b1, "R6");
    // R2 / R3: leading zeros, then first one, then inversion
    send_word(64'h58, 8, 1'b1, "R2");
    send_word(64'hF0, 8, 1'b1, "R3");
    send_word(64'h39, 6, 1'b1, "R3");
    send_word(64'h58, 8, 1'b1, "R3");
    // R8: toggling patterns checked in the same cycle they are driven
    send_word(64'hAAAA, 16, 1'b1, "R8");
    send_word(64'h5555, 16, 1'b1, "R8");
    // R7: random lengths and values, back to back
    for (int w = 0; w < 300; w++) begin
      int n;
      longint unsigned x;
      n = 1 + ($urandom % 32);
      x = {$urandom, $urandom};
      if (n < 64) x = x & ((64'd1 << n) - 1);
      send_word(x, n, 1'b1, "R7");
    end
    @(negedge clk);
    drv_valid = 1'b0;
    word_start = 1'b0;
    bit_in = 1'b0;
    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R7: queue left=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule